// File: doc/BRIEF.md
# Lockable Comparator Output Conditioner

This block sits between one analog comparator channel and the digital fabric. It holds the channel's configuration word and drives decoded control lines to the analog macro: enable, hysteresis level, power/speed class, input selects, reference scaler and bridge enables, and the resulting tap mode. The raw comparator decision enters through a two-stage synchronizer. It is then optionally inverted, gated by the channel enable, and masked by one of six external blanking request lines. The result is the conditioned output, and any change of it can raise an interrupt flag.

Software reaches the block through a simple single-cycle register port with two addresses. Address 0 is the configuration word. Address 1 holds status and the interrupt clear. Setting the lock bit freezes the whole configuration word until the next reset. The interrupt clear stays usable while the word is locked.

Top module: `cmpcond_top`

## Requirements
- R1: After reset the configuration word reads 0, the lock is clear, the interrupt output is low and the conditioned output is low.
- R2: While unlocked, a write to address 0 stores the fields and a read returns them. Layout: bit0 enable, bit1 invert, bit2 interrupt enable, bit3 scaler enable, bit4 bridge enable, bits 6:5 hysteresis, bits 8:7 power mode, bits 11:9 blanking select, bits 15:12 minus-input select, bits 17:16 plus-input select, bit31 lock. Bits 30:18 read 0.
- R3: Writing 1 to bit31 sets the lock. While locked, every write to address 0 is ignored, including a write of 0 to bit31. Only reset clears the lock.
- R4: The raw comparator bit passes through two synchronizing flops. A change driven between edges appears on the conditioned output after the second following rising edge, and not after the first.
- R5: With the channel enabled and no blanking, the conditioned output equals the synchronized raw bit XOR the invert bit.
- R6: A blanking select code k from 1 to 6 chooses blankReq[k-1]. While that line is high, the conditioned output is low regardless of inversion.
- R7: Blanking select codes 0 and 7 apply no blanking, and code 7 reads back as 7.
- R8: With the enable bit clear, the conditioned output is low.
- R9: When the conditioned output changes while interrupt enable is set, the interrupt flag is set on the next rising edge. A change with interrupt enable clear leaves the flag low.
- R10: Writing address 1 with bit0 = 1 clears the interrupt flag, including while the configuration is locked.
- R11: Decoded outputs: hystLevel and pwrMode mirror their fields. speedClass is 0 for power code 0, 1 for codes 1 and 2, and 2 for code 3. tapMode is 0 when the scaler is off, 1 when the scaler is on and the bridge is off, and 2 when both are on.
- R12: A read of address 1 returns the interrupt flag in bit0 and the conditioned output in bit1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle |
| busAddr | input | 1 | 0 = configuration, 1 = status/clear |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| rawCmp | input | 1 | Raw comparator decision, asynchronous |
| blankReq | input | 6 | Blanking request lines |
| condOut | output | 1 | Conditioned comparator output |
| irqOut | output | 1 | Interrupt flag |
| chanEn | output | 1 | Channel enable to the analog macro |
| hystLevel | output | 2 | Hysteresis level |
| pwrMode | output | 2 | Power mode code |
| speedClass | output | 2 | Decoded speed class |
| inmSel | output | 4 | Minus-input select |
| inpSel | output | 2 | Plus-input select |
| scalerEn | output | 1 | Reference scaler enable |
| bridgeEn | output | 1 | Scaler bridge enable |
| tapMode | output | 2 | Decoded scaler tap mode |

## Verification
The hardest state to reach is a locked word with a pending interrupt that must still be cleared. The stimulus enables interrupts and sets the lock in the same write. It then toggles the raw input so the flag rises, attempts an unlock and a field rewrite, and checks that both are ignored before it issues the clear. Only a reset pulse afterwards returns the word to zero. The conditioning path is swept over every combination of enable, inversion, all eight blanking codes, all seven one-hot-or-idle blanking patterns and both raw levels.

// File: rtl/cmpcond_pkg.sv
package cmpcond_pkg;

  localparam int CFG_W       = 32;
  localparam int NUM_BLANK   = 6;
  localparam int BLANK_SEL_W = $clog2(NUM_BLANK + 1);

  // configuration word layout
  localparam int BIT_EN    = 0;
  localparam int BIT_INV   = 1;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_SCAL  = 3;
  localparam int BIT_BRG   = 4;
  localparam int HYST_LSB  = 5;
  localparam int HYST_W    = 2;
  localparam int PWR_LSB   = 7;
  localparam int PWR_W     = 2;
  localparam int BLK_LSB   = 9;
  localparam int INM_LSB   = 12;
  localparam int INM_W     = 4;
  localparam int INP_LSB   = 16;
  localparam int INP_W     = 2;
  localparam int BIT_LOCK  = CFG_W - 1;

  // status word layout
  localparam int ST_FLAG = 0;
  localparam int ST_OUT  = 1;

  typedef enum logic [1:0] {
    SPEED_HIGH = 2'd0,
    SPEED_MED  = 2'd1,
    SPEED_ULP  = 2'd2
  } speedClass_e;

  typedef enum logic [1:0] {
    TAP_OFF    = 2'd0,
    TAP_FLAT   = 2'd1,
    TAP_GRADED = 2'd2
  } tapMode_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic                   enable;
    logic                   invert;
    logic                   irqEn;
    logic [BLANK_SEL_W-1:0] blankSel;
    logic                   irqClr;
  } dpCtrl_t;

endpackage

// File: rtl/cmpcond_regs.sv
module cmpcond_regs
  import cmpcond_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busAddr,
  input  logic [CFG_W-1:0] busWdata,
  output logic [CFG_W-1:0] busRdata,
  input  logic             condOut,
  input  logic             irqFlag,
  output dpCtrl_t          dpCtrl,
  output logic             chanEn,
  output logic [HYST_W-1:0] hystLevel,
  output logic [PWR_W-1:0]  pwrMode,
  output logic [1:0]        speedClass,
  output logic [INM_W-1:0]  inmSel,
  output logic [INP_W-1:0]  inpSel,
  output logic              scalerEn,
  output logic              bridgeEn,
  output logic [1:0]        tapMode
);

  localparam logic [CFG_W-1:0] FIELD_MASK =
      (CFG_W'(1) << BIT_EN) | (CFG_W'(1) << BIT_INV) | (CFG_W'(1) << BIT_IRQEN) |
      (CFG_W'(1) << BIT_SCAL) | (CFG_W'(1) << BIT_BRG) |
      (CFG_W'((1 << HYST_W) - 1) << HYST_LSB) |
      (CFG_W'((1 << PWR_W) - 1) << PWR_LSB) |
      (CFG_W'((1 << BLANK_SEL_W) - 1) << BLK_LSB) |
      (CFG_W'((1 << INM_W) - 1) << INM_LSB) |
      (CFG_W'((1 << INP_W) - 1) << INP_LSB) |
      (CFG_W'(1) << BIT_LOCK);

  logic [CFG_W-1:0] cfgQ;
  logic             lockQ;
  logic             cfgWrite;
  logic             clrWrite;

  assign lockQ    = cfgQ[BIT_LOCK];
  assign cfgWrite = busWrEn && !busAddr && !lockQ;
  assign clrWrite = busWrEn && busAddr && busWdata[ST_FLAG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWrite) begin
      cfgQ <= busWdata & FIELD_MASK;
    end
  end

  // strobes toward the datapath
  always_comb begin
    dpCtrl.enable   = cfgQ[BIT_EN];
    dpCtrl.invert   = cfgQ[BIT_INV];
    dpCtrl.irqEn    = cfgQ[BIT_IRQEN];
    dpCtrl.blankSel = cfgQ[BLK_LSB +: BLANK_SEL_W];
    dpCtrl.irqClr   = clrWrite;
  end

  // decoded controls toward the analog macro
  assign chanEn    = cfgQ[BIT_EN];
  assign hystLevel = cfgQ[HYST_LSB +: HYST_W];
  assign pwrMode   = cfgQ[PWR_LSB +: PWR_W];
  assign inmSel    = cfgQ[INM_LSB +: INM_W];
  assign inpSel    = cfgQ[INP_LSB +: INP_W];
  assign scalerEn  = cfgQ[BIT_SCAL];
  assign bridgeEn  = cfgQ[BIT_BRG];

  always_comb begin
    unique case (pwrMode)
      2'd0:    speedClass = SPEED_HIGH;
      2'd3:    speedClass = SPEED_ULP;
      default: speedClass = SPEED_MED;
    endcase
  end

  always_comb begin
    if (!scalerEn)     tapMode = TAP_OFF;
    else if (bridgeEn) tapMode = TAP_GRADED;
    else               tapMode = TAP_FLAT;
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (busAddr) begin
      busRdata[ST_FLAG] = irqFlag;
      busRdata[ST_OUT]  = condOut;
    end else begin
      busRdata = cfgQ;
    end
  end

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(cfgQ));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!busAddr) |-> (busRdata[BIT_LOCK-1:INP_LSB+INP_W] == '0));

endmodule

// File: rtl/cmpcond_path.sv
module cmpcond_path
  import cmpcond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rawCmp,
  input  logic [NUM_BLANK-1:0] blankReq,
  input  dpCtrl_t              dpCtrl,
  output logic                 condOut,
  output logic                 irqFlag
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncBit;
  logic                   blankHit;
  logic                   condPrev;
  logic                   changeEv;

  generate
    if (SYNC_STAGES < 2) begin : g_badDepth
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawCmp};
  end
  assign syncBit = syncQ[SYNC_STAGES-1];

  // reserved select codes match no line
  always_comb begin
    blankHit = 1'b0;
    for (int k = 0; k < NUM_BLANK; k++) begin
      if (dpCtrl.blankSel == BLANK_SEL_W'(k + 1)) blankHit = blankReq[k];
    end
  end

  assign condOut = dpCtrl.enable & (syncBit ^ dpCtrl.invert) & ~blankHit;

  assign changeEv = condOut ^ condPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      condPrev <= condOut;
      if (changeEv && dpCtrl.irqEn) irqFlag <= 1'b1;
      else if (dpCtrl.irqClr)       irqFlag <= 1'b0;
    end
  end

  a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(dpCtrl.irqEn));

  a_r10_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(dpCtrl.irqClr));

  a_r6_blank_forces_low: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.blankSel != '0 && int'(dpCtrl.blankSel) <= NUM_BLANK &&
     blankReq[dpCtrl.blankSel - 1'b1]) |-> !condOut);

  a_r8_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.enable |-> !condOut);

endmodule

// File: rtl/cmpcond_top.sv
module cmpcond_top
  import cmpcond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busAddr,
  input  logic [CFG_W-1:0]     busWdata,
  output logic [CFG_W-1:0]     busRdata,
  input  logic                 rawCmp,
  input  logic [NUM_BLANK-1:0] blankReq,
  output logic                 condOut,
  output logic                 irqOut,
  output logic                 chanEn,
  output logic [HYST_W-1:0]    hystLevel,
  output logic [PWR_W-1:0]     pwrMode,
  output logic [1:0]           speedClass,
  output logic [INM_W-1:0]     inmSel,
  output logic [INP_W-1:0]     inpSel,
  output logic                 scalerEn,
  output logic                 bridgeEn,
  output logic [1:0]           tapMode
);

  dpCtrl_t dpCtrl;
  logic    condW;
  logic    flagW;

  cmpcond_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .condOut    (condW),
    .irqFlag    (flagW),
    .dpCtrl     (dpCtrl),
    .chanEn     (chanEn),
    .hystLevel  (hystLevel),
    .pwrMode    (pwrMode),
    .speedClass (speedClass),
    .inmSel     (inmSel),
    .inpSel     (inpSel),
    .scalerEn   (scalerEn),
    .bridgeEn   (bridgeEn),
    .tapMode    (tapMode)
  );

  cmpcond_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .rawCmp   (rawCmp),
    .blankReq (blankReq),
    .dpCtrl   (dpCtrl),
    .condOut  (condW),
    .irqFlag  (flagW)
  );

  assign condOut = condW;
  assign irqOut  = flagW;

endmodule

// File: tb/sim_cmpcond_top.sv
module sim_cmpcond_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busAddr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rawCmp = 1'b0;
  logic [5:0]  blankReq = '0;
  logic        condOut, irqOut, chanEn, scalerEn, bridgeEn;
  logic [1:0]  hystLevel, pwrMode, speedClass, inpSel, tapMode;
  logic [3:0]  inmSel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cmpcond_top u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rawCmp(rawCmp),
    .blankReq(blankReq), .condOut(condOut), .irqOut(irqOut),
    .chanEn(chanEn), .hystLevel(hystLevel), .pwrMode(pwrMode),
    .speedClass(speedClass), .inmSel(inmSel), .inpSel(inpSel),
    .scalerEn(scalerEn), .bridgeEn(bridgeEn), .tapMode(tapMode)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(bit en, bit inv, bit ie, bit sc, bit br,
      int hy, int pw, int bs, int inm, int inp, bit lk);
    logic [31:0] w = '0;
    w[0] = en; w[1] = inv; w[2] = ie; w[3] = sc; w[4] = br;
    w[6:5] = hy[1:0]; w[8:7] = pw[1:0]; w[11:9] = bs[2:0];
    w[15:12] = inm[3:0]; w[17:16] = inp[1:0]; w[31] = lk;
    return w;
  endfunction

  task automatic busWrite(bit addr, logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(bit addr, output logic [31:0] data);
    busAddr = addr; #1;
    data = busRdata;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] w;
    cycles(3);
    // R1 reset state
    busRead(0, rd); check("R1 cfg", rd, 0);
    check("R1 cond", {31'b0, condOut}, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
    @(negedge clk); rstN = 1'b1;
    cycles(2);
    busRead(0, rd); check("R1 cfg after release", rd, 0);

    // R2 field store and readback, reserved bits
    w = mkCfg(1, 0, 0, 1, 0, 2, 1, 5, 9, 3, 0);
    busWrite(0, w | 32'h7FFC_0000);
    busRead(0, rd); check("R2 readback", rd, w);
    check("R2 inmSel", {28'b0, inmSel}, 9);
    check("R2 inpSel", {30'b0, inpSel}, 3);
    check("R2 chanEn", {31'b0, chanEn}, 1);

    // R11 decode sweep
    for (int pw = 0; pw < 4; pw++) begin
      for (int sb = 0; sb < 4; sb++) begin
        busWrite(0, mkCfg(0, 0, 0, sb[0], sb[1], 3 - pw, pw, 0, 0, 0, 0));
        check("R11 pwrMode", {30'b0, pwrMode}, pw);
        check("R11 hystLevel", {30'b0, hystLevel}, 3 - pw);
        check("R11 speedClass", {30'b0, speedClass}, (pw == 0) ? 0 : (pw == 3) ? 2 : 1);
        check("R11 tapMode", {30'b0, tapMode}, !sb[0] ? 0 : (sb[1] ? 2 : 1));
        check("R11 scaler/bridge", {30'b0, bridgeEn, scalerEn}, sb);
      end
    end

    // R7 reserved code reads back
    busWrite(0, mkCfg(1, 0, 0, 0, 0, 0, 0, 7, 0, 0, 0));
    busRead(0, rd); check("R7 code7 readback", {29'b0, rd[11:9]}, 7);

    // R5 R6 R7 R8 conditioning sweep
    for (int en = 0; en < 2; en++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int bs = 0; bs < 8; bs++) begin
          busWrite(0, mkCfg(en[0], inv[0], 0, 0, 0, 0, 0, bs, 0, 0, 0));
          for (int rv = 0; rv < 2; rv++) begin
            @(negedge clk); rawCmp = rv[0]; blankReq = '0;
            cycles(3);
            for (int bp = 0; bp < 7; bp++) begin
              bit hit;
              bit exp;
              @(negedge clk);
              blankReq = (bp == 0) ? 6'b0 : 6'(1 << (bp - 1));
              #1;
              hit = (bs >= 1 && bs <= 6 && bp == bs);
              exp = en[0] & (rv[0] ^ inv[0]) & !hit;
              if (en == 0)          check("R8 disabled", {31'b0, condOut}, exp);
              else if (hit)         check("R6 blanked", {31'b0, condOut}, exp);
              else if (bs == 0 || bs == 7) check("R7 no blank", {31'b0, condOut}, exp);
              else                  check("R5 invert", {31'b0, condOut}, exp);
            end
          end
        end
      end
    end
    @(negedge clk); blankReq = '0; rawCmp = 1'b0;

    // R4 synchronizer latency
    busWrite(0, mkCfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    cycles(3);
    @(negedge clk); rawCmp = 1'b1;
    @(posedge clk); #1; check("R4 after one edge", {31'b0, condOut}, 0);
    @(posedge clk); #1; check("R4 after two edges", {31'b0, condOut}, 1);
    @(negedge clk); rawCmp = 1'b0;
    cycles(3);

    // R9 no flag when interrupt disabled
    busWrite(1, 32'h1);
    @(negedge clk); rawCmp = 1'b1;
    cycles(4);
    check("R9 no irq when disabled", {31'b0, irqOut}, 0);
    @(negedge clk); rawCmp = 1'b0;
    cycles(4);

    // R9 flag timing with interrupt enabled, and lock at the same time
    busWrite(0, mkCfg(1, 0, 1, 0, 0, 1, 2, 0, 4, 1, 1));
    cycles(2);
    busWrite(1, 32'h1);
    check("R10 clear idle", {31'b0, irqOut}, 0);
    @(negedge clk); rawCmp = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R9 not yet set", {31'b0, irqOut}, 0);
    @(posedge clk); #1;
    check("R9 set on change", {31'b0, irqOut}, 1);
    busRead(1, rd); check("R12 status", rd, 32'h3);

    // R3 lock ignores writes, including unlock
    w = mkCfg(1, 0, 1, 0, 0, 1, 2, 0, 4, 1, 1);
    busWrite(0, 32'h0);
    busRead(0, rd); check("R3 unlock ignored", rd, w);
    busWrite(0, mkCfg(0, 1, 0, 1, 1, 3, 3, 2, 15, 2, 1));
    busRead(0, rd); check("R3 rewrite ignored", rd, w);
    check("R3 chanEn held", {31'b0, chanEn}, 1);

    // R10 clear while locked
    busWrite(1, 32'h1);
    check("R10 clear locked", {31'b0, irqOut}, 0);
    busRead(1, rd); check("R12 status after clear", rd, 32'h2);

    // R3 only reset unlocks
    @(negedge clk); rstN = 1'b0; rawCmp = 1'b0;
    #1; busRead(0, rd); check("R3 reset clears", rd, 0);
    @(negedge clk); rstN = 1'b1;
    busWrite(0, mkCfg(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    busRead(0, rd); check("R3 writable after reset", rd, 32'h2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule